// File: doc/BRIEF.md
# Configurable 32-Pin GPIO Port Controller

This block is a register-mapped general-purpose I/O port of up to 32 pins. Software drives the output latch and the pin directions through whole-port registers, either by overwriting them or through set-only and clear-only aliases. Each pin also has a configuration word that holds its direction, its input-buffer disconnect bit and its pull selection. The direction bit is a single piece of state, so the port-wide direction view and each pin's configuration word always agree.

Every pin has an external driver that can drive high, drive low or float, given as a drive-enable and a value. Both signals pass through a multi-flop synchronizer. Each pin then resolves a level, and this level is what the input register reports. The pin's own driver wins when the pin is an output, so an output reads back its own value. On an input, the external level counts only when the input buffer is connected and the external driver is enabled. Otherwise the pull decides, and with no pull the last resolved value is held. An output pin that the outside world drives to the opposite level sets a sticky per-pin conflict bit. The OR of all conflict bits is brought out as an error flag.

Register accesses are single-cycle strobes on a word-addressed bus. Read data and its valid flag appear one cycle after the read strobe.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the registers at word offsets 0 (OUT), 1 (OUTSET), 2 (OUTCLR), 3 (IN), 4 (DIR), 5 (DIRSET), 6 (DIRCLR) and 7 (STATUS) all read 0, and pin_out and pin_oe are 0.
- R2: A pin's configuration word sits at word offset 32+n and has these fields: bit 0 is the direction (1 = output), bit 1 is input disconnect (1 = disconnected), and bits [3:2] are the pull (01 = down, 11 = up, 00 or 10 = none). After reset every configuration word reads 0x2. Bits [31:4] are not stored and read 0.
- R3: Writing DIR replaces all direction bits. Writing a configuration word also sets that pin's DIR bit from bit 0. DIR and bit 0 of every configuration word always read the same, and pin_oe equals DIR.
- R4: Writing DIRSET sets the DIR bits written as 1, and writing DIRCLR clears them. Other bits are unchanged. Reads of DIRSET and DIRCLR return DIR.
- R5: OUT is written directly, OUTSET sets the OUT bits written as 1, and OUTCLR clears them. pin_out equals OUT, and reads of OUTSET and OUTCLR return OUT.
- R6: On a connected input pin, IN follows the synchronized external level. When the external driver is released with no pull selected, IN keeps the last resolved value.
- R7: On an input pin that is disconnected or not externally driven, pull-up makes IN read 1 and pull-down makes IN read 0. With configuration 0 the pin instead reads the external level.
- R8: On an output pin, IN reports the pin's own OUT bit.
- R9: A pin that is an output and is externally driven to the opposite level sets its STATUS bit. The bit is sticky and is cleared by writing 1 to it. err_flag is the OR of all STATUS bits. Equal levels raise nothing.
- R10: rd_valid is high exactly in the cycle after rd_en, with rdata valid in that cycle. Unmapped offsets (such as 8, or anything above the last pin) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| ext_drive_en | input | NPINS | External driver enable per pin |
| ext_drive_val | input | NPINS | External driven level per pin |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output enable per pin |
| err_flag | output | 1 | OR of the sticky conflict bits |

## Verification
The hardest states to reach from the ports are the held value on a floating input and the conflict bit outliving its cause. Both depend on the order of events across the synchronizer delay. For the held value, the bench drives a pattern with the input buffers connected and waits past the synchronizer and the level register. It then drops the external drive and changes the value behind it, and checks that IN does not move. For the conflict, the bench first drives an output pin externally to the same level, where nothing may be raised. It then flips the external level, removes the external drive, and checks that STATUS and err_flag stay set until a write of 1 clears them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int OFF_OUT      = 0;
   localparam int OFF_OUTSET   = 1;
   localparam int OFF_OUTCLR   = 2;
   localparam int OFF_IN       = 3;
   localparam int OFF_DIR      = 4;
   localparam int OFF_DIRSET   = 5;
   localparam int OFF_DIRCLR   = 6;
   localparam int OFF_STATUS   = 7;
   localparam int OFF_CFG_BASE = 32;

   typedef enum logic [1:0] {
      PULL_NONE = 2'b00,
      PULL_DOWN = 2'b01,
      PULL_RSVD = 2'b10,
      PULL_UP   = 2'b11
   } pull_e;

   // packed so that pull lands in bits [3:2] and in_disc in bit 1 of the word
   typedef struct packed {
      pull_e pull;
      logic  in_disc;
   } pin_cfg_t;

   localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, in_disc: 1'b1};
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_port_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     dir,
   input  logic     drv,
   input  pin_cfg_t cfg,
   input  logic     ext_en,
   input  logic     ext_val,
   input  logic     err_clr,
   output logic     level,
   output logic     err
);
   logic level_d;
   logic clash;

   always_comb begin
      if (dir)                           level_d = drv;
      else if (ext_en && !cfg.in_disc)   level_d = ext_val;
      else if (cfg.pull == PULL_UP)      level_d = 1'b1;
      else if (cfg.pull == PULL_DOWN)    level_d = 1'b0;
      else                               level_d = level;
   end

   assign clash = dir && ext_en && (ext_val != drv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         err   <= 1'b0;
      end else begin
         level <= level_d;
         if (clash)        err <= 1'b1;
         else if (err_clr) err <= 1'b0;
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int AW          = 7,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rd_valid,
   input  logic [NPINS-1:0] ext_drive_en,
   input  logic [NPINS-1:0] ext_drive_val,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             err_flag
);
   localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1;

   generate
      if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
         $error("gpio_port_ctrl: NPINS must be 1..32");
      end
      if (DW < NPINS || DW < 4) begin : g_bad_dw
         $error("gpio_port_ctrl: DW must cover NPINS and the 4-bit config word");
      end
      if ((1 << AW) < OFF_CFG_BASE + NPINS) begin : g_bad_aw
         $error("gpio_port_ctrl: AW too small for config window");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPINS-1:0] out_q, dir_q, level, err_vec, ext_en_s, ext_val_s, err_clr;
   pin_cfg_t         cfg_q [NPINS];
   logic [AW-1:0]    cfg_off;
   logic             cfg_hit;
   logic [IDXW-1:0]  cfg_idx;
   logic [NPINS-1:0] wmask;
   logic [DW-1:0]    rd_word;

   assign wmask   = wdata[NPINS-1:0];
   assign cfg_off = addr - AW'(OFF_CFG_BASE);
   assign cfg_hit = (addr >= AW'(OFF_CFG_BASE)) && (cfg_off < AW'(NPINS));
   assign cfg_idx = cfg_off[IDXW-1:0];

   // ---------------- register writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         for (int i = 0; i < NPINS; i++) cfg_q[i] <= CFG_RESET;
      end else if (wr_en) begin
         if (addr == AW'(OFF_OUT))    out_q <= wmask;
         if (addr == AW'(OFF_OUTSET)) out_q <= out_q | wmask;
         if (addr == AW'(OFF_OUTCLR)) out_q <= out_q & ~wmask;
         if (addr == AW'(OFF_DIR))    dir_q <= wmask;
         if (addr == AW'(OFF_DIRSET)) dir_q <= dir_q | wmask;
         if (addr == AW'(OFF_DIRCLR)) dir_q <= dir_q & ~wmask;
         if (cfg_hit) begin
            dir_q[cfg_idx] <= wdata[0];
            cfg_q[cfg_idx] <= pin_cfg_t'(wdata[3:1]);
         end
      end
   end

   assign err_clr = (wr_en && addr == AW'(OFF_STATUS)) ? wmask : '0;

   // ---------------- external input synchronizer ----------------
   gpio_sync #(.W(2*NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_drive_en, ext_drive_val}),
      .q     ({ext_en_s, ext_val_s})
   );

   // ---------------- per-pin resolution ----------------
   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         gpio_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (dir_q[p]),
            .drv     (out_q[p]),
            .cfg     (cfg_q[p]),
            .ext_en  (ext_en_s[p]),
            .ext_val (ext_val_s[p]),
            .err_clr (err_clr[p]),
            .level   (level[p]),
            .err     (err_vec[p])
         );
      end
   endgenerate

   // ---------------- read path ----------------
   always_comb begin
      rd_word = '0;
      if (addr == AW'(OFF_OUT) || addr == AW'(OFF_OUTSET) || addr == AW'(OFF_OUTCLR))
         rd_word = DW'(out_q);
      else if (addr == AW'(OFF_IN))
         rd_word = DW'(level);
      else if (addr == AW'(OFF_DIR) || addr == AW'(OFF_DIRSET) || addr == AW'(OFF_DIRCLR))
         rd_word = DW'(dir_q);
      else if (addr == AW'(OFF_STATUS))
         rd_word = DW'(err_vec);
      else if (cfg_hit)
         rd_word = DW'({cfg_q[cfg_idx], dir_q[cfg_idx]});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_word;
      end
   end

   assign pin_out  = out_q;
   assign pin_oe   = dir_q;
   assign err_flag = |err_vec;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
   import gpio_port_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 7,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [AW-1:0]    addr,
   input logic [DW-1:0]    wdata,
   input logic             rd_valid,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic             err_flag
);
   logic [NPINS-1:0] m;
   assign m = wdata[NPINS-1:0];

   a_r4_dirset_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_DIRSET)) |=> ((pin_oe & $past(m)) == $past(m)));

   a_r4_dirclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_DIRCLR)) |=> ((pin_oe & $past(m)) == '0));

   a_r5_outset_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_OUTSET)) |=> ((pin_out & $past(m)) == $past(m)));

   a_r5_outclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_OUTCLR)) |=> ((pin_out & $past(m)) == '0));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(wr_en && addr == AW'(OFF_STATUS))) |=> err_flag);

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rd_valid (rd_valid),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .err_flag (err_flag)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
   localparam int N = 32;
   localparam int A_OUT = 0, A_OUTSET = 1, A_OUTCLR = 2, A_IN = 3;
   localparam int A_DIR = 4, A_DIRSET = 5, A_DIRCLR = 6, A_STAT = 7, A_CFG = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [6:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rd_valid;
   logic [N-1:0]  ext_en = '0, ext_val = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic          err_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpio_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
      .ext_drive_en(ext_en), .ext_drive_val(ext_val),
      .pin_out(pin_out), .pin_oe(pin_oe), .err_flag(err_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 7'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = 7'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v, exp_dir, exp_out, pat;
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state of port-wide registers
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         chk($sformatf("R1 reg %0d", a), v, 32'h0);
      end
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 pin_out", pin_out, 32'h0);

      // R2 every configuration word resets to 0x2
      for (int i = 0; i < N; i++) begin
         rd(A_CFG + i, v);
         chk($sformatf("R2 cfg %0d reset", i), v, 32'h2);
      end

      // R3/R4 direction consistency through DIRSET/DIRCLR/DIR
      wr(A_DIRSET, 32'h8000_0001);
      rd(A_DIR, v);          chk("R4 DIRSET", v, 32'h8000_0001);
      rd(A_CFG, v);          chk("R3 cfg0 dir", v & 1, 32'h1);
      rd(A_CFG + 31, v);     chk("R3 cfg31 dir", v & 1, 32'h1);
      rd(A_DIRSET, v);       chk("R4 DIRSET readback", v, 32'h8000_0001);
      chk("R3 pin_oe", pin_oe, 32'h8000_0001);
      wr(A_DIRCLR, 32'h8000_0001);
      rd(A_DIR, v);          chk("R4 DIRCLR", v, 32'h0);
      rd(A_CFG, v);          chk("R3 cfg0 after DIRCLR", v, 32'h2);
      wr(A_DIR, 32'h8000_0001);
      rd(A_CFG + 31, v);     chk("R3 cfg31 after DIR", v, 32'h3);
      wr(A_DIR, 32'h0);

      // R3 sweep: config write moves the matching DIR bit only
      for (int i = 0; i < N; i++) begin
         wr(A_CFG + i, 32'h1);
         rd(A_DIR, v);
         chk($sformatf("R3 cfg %0d -> DIR", i), v, 32'h1 << i);
         wr(A_CFG + i, 32'h2);
      end

      // R4 set/clear combinations
      exp_dir = 32'h0;
      wr(A_DIRSET, 32'h0000_FF00); exp_dir |= 32'h0000_FF00;
      wr(A_DIRSET, 32'h00F0_0000); exp_dir |= 32'h00F0_0000;
      wr(A_DIRCLR, 32'h0000_0F00); exp_dir &= ~32'h0000_0F00;
      rd(A_DIRCLR, v);       chk("R4 mixed set/clear", v, exp_dir);
      wr(A_DIR, 32'h0);

      // R2 unstored upper bits
      wr(A_CFG + 5, 32'hFFFF_FFFE);
      rd(A_CFG + 5, v);      chk("R2 upper bits dropped", v, 32'hE);
      wr(A_CFG + 5, 32'h2);

      // R5 output latch
      exp_out = 32'h1234_5678;
      wr(A_OUT, exp_out);
      wr(A_OUTSET, 32'h8000_0001); exp_out |= 32'h8000_0001;
      wr(A_OUTCLR, 32'h0000_0078); exp_out &= ~32'h0000_0078;
      rd(A_OUT, v);          chk("R5 OUT", v, exp_out);
      rd(A_OUTSET, v);       chk("R5 OUTSET readback", v, exp_out);
      rd(A_OUTCLR, v);       chk("R5 OUTCLR readback", v, exp_out);
      chk("R5 pin_out", pin_out, exp_out);
      wr(A_OUT, 32'h0);

      // R6 connected inputs follow the external level, hold on release
      for (int i = 0; i < N; i++) wr(A_CFG + i, 32'h0);
      pat = 32'hA5C3_0F96;
      @(negedge clk); ext_en = '1; ext_val = pat;
      idle(5);
      rd(A_IN, v);           chk("R6 IN pattern", v, pat);
      @(negedge clk); ext_val = ~pat;
      idle(5);
      rd(A_IN, v);           chk("R6 IN inverted", v, ~pat);
      @(negedge clk); ext_en = '0;
      idle(5);
      @(negedge clk); ext_val = '0;
      idle(5);
      rd(A_IN, v);           chk("R6 IN held after release", v, ~pat);

      // R7 pulls
      @(negedge clk); ext_en = '1; ext_val = '0;
      idle(5);
      wr(A_CFG, 32'hE); idle(3);
      rd(A_IN, v);           chk("R7 pull-up over ext 0", v & 1, 32'h1);
      wr(A_CFG, 32'h0); idle(3);
      rd(A_IN, v);           chk("R7 cfg0 reads ext 0", v & 1, 32'h0);
      @(negedge clk); ext_val = '1;
      idle(5);
      wr(A_CFG, 32'h6); idle(3);
      rd(A_IN, v);           chk("R7 pull-down over ext 1", v & 1, 32'h0);
      wr(A_CFG, 32'h0); idle(3);
      rd(A_IN, v);           chk("R7 cfg0 reads ext 1", v & 1, 32'h1);
      @(negedge clk); ext_en = '0; ext_val = '0;
      idle(5);
      wr(A_CFG, 32'h4); idle(3);
      rd(A_IN, v);           chk("R7 pull-down on floating input", v & 1, 32'h0);
      wr(A_CFG, 32'hC); idle(3);
      rd(A_IN, v);           chk("R7 pull-up on floating input", v & 1, 32'h1);

      // R8 output loop-back
      wr(A_CFG, 32'h1);
      wr(A_OUTSET, 32'h1); idle(3);
      rd(A_IN, v);           chk("R8 IN follows own high", v & 1, 32'h1);
      chk("R8 pin_out/oe", {30'h0, pin_oe[0], pin_out[0]}, 32'h3);
      wr(A_OUTCLR, 32'h1); idle(3);
      rd(A_IN, v);           chk("R8 IN follows own low", v & 1, 32'h0);
      chk("R9 no error without external drive", {31'h0, err_flag}, 32'h0);

      // R9 conflict detection
      wr(A_OUTSET, 32'h1);
      @(negedge clk); ext_en = 32'h1; ext_val = 32'h1;
      idle(5);
      chk("R9 equal levels no error", {31'h0, err_flag}, 32'h0);
      @(negedge clk); ext_val = 32'h0;
      idle(5);
      chk("R9 opposite levels error", {31'h0, err_flag}, 32'h1);
      rd(A_STAT, v);         chk("R9 STATUS bit0", v, 32'h1);
      @(negedge clk); ext_en = '0;
      idle(5);
      chk("R9 error sticky", {31'h0, err_flag}, 32'h1);
      wr(A_STAT, 32'h1); idle(1);
      chk("R9 error cleared", {31'h0, err_flag}, 32'h0);
      rd(A_STAT, v);         chk("R9 STATUS cleared", v, 32'h0);

      // R10 read timing and unmapped offsets
      rd(8, v);              chk("R10 unmapped 8", v, 32'h0);
      rd(100, v);            chk("R10 unmapped 100", v, 32'h0);
      @(negedge clk); rd_en = 1'b1; addr = 7'(A_DIR);
      chk("R10 no valid before strobe edge", {31'h0, rd_valid}, 32'h0);
      @(negedge clk); rd_en = 1'b0;
      chk("R10 valid after strobe", {31'h0, rd_valid}, 32'h1);
      @(negedge clk);
      chk("R10 valid drops", {31'h0, rd_valid}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule